// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides its input clock by N = 32·B + A and marks the end of each divided period with a one-cycle pulse. It sits in the feedback path of a frequency synthesizer. Inside, a small prescaler counter runs either 33 or 32 input cycles per prescaler cycle, depending on a modulus-select line. Two down-counters steer that line. The swallow counter holds the prescaler at 33 for the first A prescaler cycles of each period. The main counter ends the period after B prescaler cycles. Because N is built from two moduli, the divider covers every integer from 992 to 32767 without a wide binary comparator on the input clock.

The settings `swallow_cnt` (A, 0 to 31) and `main_cnt` (B, 3 to 1023, with B ≥ A) are plain configuration pins. The block captures them only at a period boundary or while it is held. A `hold` input, driven by the power-down logic, parks the block at its load point. Releasing `hold` restarts counting from zero, so the first period after release is aligned and complete. The block has no streaming data path, so no valid/ready handshake is used. All pins are plain control and status pins.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While running with fixed settings, successive `div_pulse` assertions are exactly 32·B + A input clock cycles apart.
- R2: `div_pulse` is high for exactly one clock cycle per divided period.
- R3: In each period, `mod_sel` is high (prescaler modulus 33) for the first A prescaler cycles, which is 33·A input cycles. It is low for the remaining B − A prescaler cycles, which is 32·(B − A) input cycles. When A = 0, `mod_sel` stays low for the whole period.
- R4: While `hold` is high, `div_pulse` stays low and all counters sit at their load point. If cycle 1 is the first cycle in which `hold` is low, the first `div_pulse` is high in cycle N.
- R5: `swallow_cnt` and `main_cnt` are captured only while held or on the clock edge that ends a period. A change in the middle of a period leaves the length of that period unchanged, and the next period uses the new values.
- R6: The extreme settings divide correctly: B = 31, A = 0 gives 992; B = 1023, A = 31 gives 32767; B = A gives 33·B.
- R7: While `rst_n` is low, `div_pulse` and `mod_sel` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Power-down hold; parks the counters at their load point |
| swallow_cnt | input | 5 | A: number of prescaler cycles per period run at modulus 33 |
| main_cnt | input | 10 | B: number of prescaler cycles per period |
| div_pulse | output | 1 | One-cycle pulse on the last input cycle of each period |
| mod_sel | output | 1 | Prescaler modulus select: 1 selects 33, 0 selects 32 |

## Verification
A wrong internal count shows at the ports within one divided period. The spacing between `div_pulse` assertions moves away from 32·B + A, and the number of cycles with `mod_sel` high in that period moves away from 33·A. A slipped prescaler state changes the period by at most one prescaler cycle. A swallow count that fails to run out leaves `mod_sel` high for too long. Either fault is caught at the next pulse. Settings captured at the wrong time show up as a malformed period right after a mid-period change. A bad restart shows up as a wrong latency from the release of `hold` to the first pulse.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PRE_MOD = 32;
  localparam int unsigned SWALLOW_W = 5;
  localparam int unsigned MAIN_W = 10;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned P = 32,
  localparam int unsigned CW = $clog2(P + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic mod_hi,
  output logic cyc_end
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;

  // Terminal count: P for modulus P+1, P-1 for modulus P
  assign last_val = mod_hi ? CW'(P) : CW'(P - 1);
  assign cyc_end  = !load && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load || cyc_end)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assert_pc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(P));

  assert_pc_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int unsigned AW = 5,
  parameter int unsigned BW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cyc_end,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  output logic          mod_hi,
  output logic          period_end
);
  logic [AW-1:0] sw_q;
  logic [BW-1:0] mc_q;

  assign mod_hi     = (sw_q != '0);
  assign period_end = cyc_end && (mc_q == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      mc_q <= BW'(1);
    end else if (load || period_end) begin
      sw_q <= a_in;
      mc_q <= b_in;
    end else if (cyc_end) begin
      mc_q <= mc_q - 1'b1;
      if (sw_q != '0) sw_q <= sw_q - 1'b1;
    end
  end

  assert_main_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load)) |-> (mc_q != '0));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);

  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !period_end);

  // modulus 33 can only begin at the start of a new period
  assert_mod_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load) && $rose(mod_hi)) |-> $past(period_end));
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int unsigned P  = psd_pkg::PRE_MOD,
  parameter int unsigned AW = psd_pkg::SWALLOW_W,
  parameter int unsigned BW = psd_pkg::MAIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [AW-1:0] swallow_cnt,
  input  logic [BW-1:0] main_cnt,
  output logic          div_pulse,
  output logic          mod_sel
);
  logic run_q;
  logic load;
  logic cyc_end;

  // the first edge after reset captures the settings, like a hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign load = hold || !run_q;

  psd_prescaler #(.P(P)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .mod_hi  (mod_sel),
    .cyc_end (cyc_end)
  );

  psd_swallow_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .cyc_end    (cyc_end),
    .a_in       (swallow_cnt),
    .b_in       (main_cnt),
    .mod_hi     (mod_sel),
    .period_end (div_pulse)
  );

  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!div_pulse && !mod_sel));
endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold = 1'b1;
  logic [4:0] swallow_cnt = '0;
  logic [9:0] main_cnt = 10'd3;
  logic       div_pulse;
  logic       mod_sel;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
    .div_pulse(div_pulse), .mod_sel(mod_sel)
  );

  function automatic int exp_div(int a, int b);
    return 32 * b + a;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int cyc, output int modc);
    bit seen = 1'b0;
    cyc = 0;
    modc = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      cyc++;
      if (mod_sel) modc++;
      if (div_pulse) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual no pulse expected pulse");
    end
  endtask

  task automatic start(int a, int b);
    int cyc, modc;
    @(negedge clk);
    hold = 1'b1;
    swallow_cnt = 5'(a);
    main_cnt = 10'(b);
    repeat (3) @(negedge clk);
    chk("R4 quiet in hold", int'(div_pulse), 0);
    hold = 1'b0;
    wait_pulse(cyc, modc);
    chk("R4 first pulse latency", cyc, exp_div(a, b) - 1);
  endtask

  task automatic run_case(string req, int a, int b);
    int cyc, modc;
    start(a, b);
    wait_pulse(cyc, modc);
    chk({req, " R1 period"}, cyc, exp_div(a, b));
    chk({req, " R3 modulus-33 cycles"}, modc, 33 * a);
    @(negedge clk);
    chk({req, " R2 pulse width"}, int'(div_pulse), 0);
  endtask

  initial begin
    int cyc, modc, a, b, npulse;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R7 reset pulse", int'(div_pulse), 0);
    chk("R7 reset mod_sel", int'(mod_sel), 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_case("R6 min", 0, 31);
    run_case("R6 B=A", 31, 31);
    run_case("R3 A=0", 0, 3);
    run_case("basic", 5, 40);

    // R5: mid-period change keeps the current period, next uses new values
    start(7, 50);
    repeat (100) @(negedge clk);
    swallow_cnt = 5'd2;
    main_cnt = 10'd33;
    wait_pulse(cyc, modc);
    chk("R5 current period kept", cyc, exp_div(7, 50) - 100);
    wait_pulse(cyc, modc);
    chk("R5 new period", cyc, exp_div(2, 33));
    chk("R5 new modulus count", modc, 33 * 2);

    // R4: hold in mid-period suppresses pulses, then restart is aligned
    repeat (200) @(negedge clk);
    hold = 1'b1;
    npulse = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (div_pulse) npulse++;
    end
    chk("R4 no pulse during hold", npulse, 0);
    hold = 1'b0;
    wait_pulse(cyc, modc);
    chk("R4 restart latency", cyc, exp_div(2, 33) - 1);

    for (int k = 0; k < 8; k++) begin
      b = 3 + int'($urandom % 98);
      a = int'($urandom % 32);
      if (a > b) a = b;
      run_case("R1 random", a, b);
    end

    run_case("R6 max", 31, 1023);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule